// File: doc/BRIEF.md
# UART Receive Address Match Filter

This block sits between the deserializer of a UART receiver and its receive data buffer. For each received word it decides whether the word is written into the buffer or dropped. It has two match channels. Each channel has its own enable bit and its own programmable address value. With filtering switched off, every word goes through. With either channel enabled, only words that carry the most significant bit set and equal an enabled address are kept. All other words are dropped.

Smart-card operation does not allow address filtering. If the smart-card flag is raised while a channel is enabled, the block lets every word through and sets a sticky configuration-error flag, which only reset clears. The decision is registered. One clock after a receive strobe, the block gives either a one-cycle buffer write, with the word on the data output, or a one-cycle discard pulse.

Top module: `uart_addr_filter`

## Requirements
- R1: With both channel enables low, every word presented with `rx_valid_i` high produces `buf_wr_o` high one clock later, with `buf_data_o` equal to that word.
- R2: With at least one channel enabled and smart-card mode off, a word whose most significant bit (bit DATA_W-1) is 0 produces `discard_o` one clock later.
- R3: With a channel enabled and smart-card mode off, a word whose most significant bit is 1 and which equals that channel's address is written to the buffer one clock later.
- R4: With filtering active, a word whose most significant bit is 1 and which equals no enabled address produces `discard_o` one clock later.
- R5: With both channels enabled, a word that matches either address is written. A word that matches neither is discarded.
- R6: The address of a disabled channel has no effect. A word that equals only the disabled channel's address is discarded while the other channel is enabled.
- R7: The comparison covers the whole word, including its top bit. An enabled address with bit DATA_W-1 at 0 never causes a write while filtering is active, even when the word equals it.
- R8: While `smartcard_i` is high, every received word is written one clock later, whatever the enables, addresses and top bit.
- R9: `cfg_err_o` becomes 1 one clock after a cycle in which `smartcard_i` is high together with either enable. It stays 1 until reset.
- R10: Every receive strobe gives exactly one of `buf_wr_o` or `discard_o`, each for a single cycle, one clock later. Neither pulses without a strobe. Strobes on consecutive cycles give consecutive results.
- R11: While reset is asserted and right after it, `buf_wr_o`, `discard_o` and `cfg_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Received word strobe |
| rx_data_i | input | DATA_W | Received word |
| match_en_a_i | input | 1 | Enable for match channel A |
| match_en_b_i | input | 1 | Enable for match channel B |
| addr_a_i | input | DATA_W | Address for channel A |
| addr_b_i | input | DATA_W | Address for channel B |
| smartcard_i | input | 1 | Smart-card mode active |
| buf_wr_o | output | 1 | Buffer write strobe |
| buf_data_o | output | DATA_W | Word to write |
| discard_o | output | 1 | Word dropped pulse |
| cfg_err_o | output | 1 | Sticky configuration error |

## Verification
Every result of this block is due exactly one clock after the inputs that cause it: the write or discard pulse, the written data, and the error flag that follows an illegal mode combination. The bench changes inputs on falling edges. At each rising edge its behavioural model records what the inputs call for, and at the following falling edge it compares all outputs with that record. Because the comparison runs every cycle, idle cycles are checked for the absence of pulses, and back-to-back strobes are checked one by one.

// File: rtl/addr_filt_pkg.sv
package addr_filt_pkg;
  typedef enum logic [1:0] {
    DEC_IDLE  = 2'd0,
    DEC_WRITE = 2'd1,
    DEC_DROP  = 2'd2
  } dec_e;
endpackage

// File: rtl/addr_match_chan.sv
module addr_match_chan #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] addr_i,
  input  logic              en_i,
  output logic              hit_o
);
  // full-width compare, top bit included
  assign hit_o = en_i && (data_i == addr_i);
endmodule

// File: rtl/addr_filt_decide.sv
module addr_filt_decide
  import addr_filt_pkg::*;
#(
  parameter int unsigned NUM_CH = 2
) (
  input  logic              valid_i,
  input  logic              msb_i,
  input  logic [NUM_CH-1:0] en_i,
  input  logic [NUM_CH-1:0] hit_i,
  input  logic              bypass_i,
  output dec_e              dec_o
);
  logic filt_on;
  assign filt_on = (|en_i) && !bypass_i;

  always_comb begin
    if (!valid_i)              dec_o = DEC_IDLE;
    else if (!filt_on)         dec_o = DEC_WRITE;
    else if (msb_i && |hit_i)  dec_o = DEC_WRITE;
    else                       dec_o = DEC_DROP;
  end
endmodule

// File: rtl/uart_addr_filter.sv
module uart_addr_filter
  import addr_filt_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              match_en_a_i,
  input  logic              match_en_b_i,
  input  logic [DATA_W-1:0] addr_a_i,
  input  logic [DATA_W-1:0] addr_b_i,
  input  logic              smartcard_i,
  output logic              buf_wr_o,
  output logic [DATA_W-1:0] buf_data_o,
  output logic              discard_o,
  output logic              cfg_err_o
);
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned MSB    = DATA_W - 1;

  logic [NUM_CH-1:0] en_v;
  logic [NUM_CH-1:0] hit_v;
  logic [DATA_W-1:0] addr_v [NUM_CH];
  dec_e              dec;

  assign en_v      = {match_en_b_i, match_en_a_i};
  assign addr_v[0] = addr_a_i;
  assign addr_v[1] = addr_b_i;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    addr_match_chan #(.DATA_W(DATA_W)) u_chan (
      .data_i (rx_data_i),
      .addr_i (addr_v[ch]),
      .en_i   (en_v[ch]),
      .hit_o  (hit_v[ch])
    );
  end

  addr_filt_decide #(.NUM_CH(NUM_CH)) u_dec (
    .valid_i  (rx_valid_i),
    .msb_i    (rx_data_i[MSB]),
    .en_i     (en_v),
    .hit_i    (hit_v),
    .bypass_i (smartcard_i),
    .dec_o    (dec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_wr_o   <= 1'b0;
      discard_o  <= 1'b0;
      buf_data_o <= '0;
      cfg_err_o  <= 1'b0;
    end else begin
      buf_wr_o  <= (dec == DEC_WRITE);
      discard_o <= (dec == DEC_DROP);
      if (dec == DEC_WRITE) buf_data_o <= rx_data_i;
      // illegal combination latches until reset
      if (smartcard_i && (|en_v)) cfg_err_o <= 1'b1;
    end
  end

  a_r10_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(buf_wr_o && discard_o));
  a_r10_result_due: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> (buf_wr_o || discard_o));
  a_r10_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> !(buf_wr_o || discard_o));
  a_r1_data_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> (!buf_wr_o || buf_data_o == $past(rx_data_i)));
  a_r2_msb_clear_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && (match_en_a_i || match_en_b_i) && !smartcard_i && !rx_data_i[MSB])
      |=> discard_o);
  a_r8_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && smartcard_i) |=> buf_wr_o);
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> cfg_err_o);
endmodule

// File: tb/tb_uart_addr_filter.sv
module tb_uart_addr_filter;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0;
  logic [DW-1:0] data = '0;
  logic          en_a = 1'b0, en_b = 1'b0, sc = 1'b0;
  logic [DW-1:0] addr_a = '0, addr_b = '0;
  logic          wr, drop, cerr;
  logic [DW-1:0] wdata;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string cur_tag = "R10";

  uart_addr_filter #(.DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(valid), .rx_data_i(data),
    .match_en_a_i(en_a), .match_en_b_i(en_b), .addr_a_i(addr_a), .addr_b_i(addr_b),
    .smartcard_i(sc), .buf_wr_o(wr), .buf_data_o(wdata), .discard_o(drop),
    .cfg_err_o(cerr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference, registered at each rising edge
  bit exp_wr, exp_drop, exp_err;
  logic [DW-1:0] exp_data;
  string exp_tag = "R11";
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_wr = 0; exp_drop = 0; exp_err = 0; exp_tag = "R11";
    end else begin
      bit keep;
      if (sc || (!en_a && !en_b)) keep = 1;
      else keep = data[DW-1] && ((en_a && data == addr_a) || (en_b && data == addr_b));
      exp_wr   = valid && keep;
      exp_drop = valid && !keep;
      if (exp_wr) exp_data = data;
      if (sc && (en_a || en_b)) exp_err = 1;
      exp_tag  = valid ? cur_tag : "R10";
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(wr == exp_wr, exp_tag, "buf_wr", wr, exp_wr);
    chk(drop == exp_drop, exp_tag, "discard", drop, exp_drop);
    chk(!(wr && drop), "R10", "both pulses", {wr, drop}, 0);
    if (exp_wr) chk(wdata == exp_data, exp_tag, "data", wdata, exp_data);
    chk(cerr == exp_err, "R9", "cfg_err", cerr, exp_err);
  end

  task automatic drive(input logic [DW-1:0] d, input bit ea, input bit eb,
                       input logic [DW-1:0] aa, input logic [DW-1:0] ab,
                       input bit s, input string tag);
    @(negedge clk);
    valid = 1; data = d; en_a = ea; en_b = eb; addr_a = aa; addr_b = ab; sc = s;
    cur_tag = tag;
  endtask

  task automatic idle();
    @(negedge clk);
    valid = 0; sc = 0; cur_tag = "R10";
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!wr && !drop && !cerr, "R11", "outputs in reset", {wr, drop, cerr}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!wr && !drop && !cerr, "R11", "outputs after reset", {wr, drop, cerr}, 0);

    // every enable / msb / match combination, back-to-back words
    for (int ea = 0; ea < 2; ea++)
      for (int eb = 0; eb < 2; eb++)
        for (int m = 0; m < 2; m++)
          for (int ha = 0; ha < 2; ha++)
            for (int hb = 0; hb < 2; hb++) begin
              logic [DW-1:0] d, aa, ab;
              string tag;
              d  = m ? 8'hA5 : 8'h25;
              aa = ha ? d : d ^ 8'h01;
              ab = hb ? d : d ^ 8'h02;
              if (!ea && !eb) tag = "R1";
              else if (!m && ((ea && ha) || (eb && hb))) tag = "R7";
              else if (!m) tag = "R2";
              else if ((!ea && ha && !hb) || (!eb && hb && !ha)) tag = "R6";
              else if (ea && eb) tag = "R5";
              else if ((ea && ha) || (eb && hb)) tag = "R3";
              else tag = "R4";
              drive(d, ea[0], eb[0], aa, ab, 1'b0, tag);
            end
    idle();

    // back-to-back mixed stream on one setting
    for (int i = 0; i < 16; i++)
      drive(8'(i * 29 + 3) | (i[0] ? 8'h80 : 8'h00), 1'b1, 1'b1,
            8'h83, 8'hF0, 1'b0, "R10");
    drive(8'h83, 1'b1, 1'b1, 8'h83, 8'hF0, 1'b0, "R5");
    drive(8'hF0, 1'b1, 1'b1, 8'h83, 8'hF0, 1'b0, "R5");
    drive(8'hF1, 1'b1, 1'b1, 8'h83, 8'hF0, 1'b0, "R4");
    idle(); idle();
    chk(!cerr, "R9", "no error yet", cerr, 0);

    // smart-card bypass and sticky error
    drive(8'h11, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, "R8");
    drive(8'h12, 1'b1, 1'b0, 8'h99, 8'h00, 1'b1, "R8");
    drive(8'h93, 1'b0, 1'b1, 8'h00, 8'h99, 1'b1, "R8");
    idle();
    drive(8'h14, 1'b1, 1'b0, 8'h94, 8'h00, 1'b0, "R2");
    idle();
    repeat (4) @(negedge clk);
    chk(cerr, "R9", "sticky after mode exit", cerr, 1);

    rst_n = 0;
    @(negedge clk);
    chk(!cerr && !wr && !drop, "R11", "reset clears error", {wr, drop, cerr}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule